// File: doc/BRIEF.md
# Auto-Negotiation Link Timer

This block is the programmable interval timer that paces link auto-negotiation on a gigabit serial link. It counts clock ticks of a 125 MHz clock (8 ns each) up to a 21-bit terminal value. Its maximum is a little under 16.8 ms. Software sets the terminal value through two 16-bit register words on a plain register port. The surrounding negotiation logic pulses `restart` to begin an interval and waits for a one-cycle `done` pulse.

The terminal value is split across two words. The low word holds bits 15:0 and the high word holds bits 20:16. Bit 0 of the low word is tied to zero, so every programmed interval is an even number of ticks. After reset the terminal value is 1,250,000 ticks, which is 10 ms. A new value is captured only when the timer is restarted, so a write never disturbs an interval in progress.

Top module: `anlt_link_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets synchronously. Afterwards the low word reads 0x12D0, the high word reads 0x0013 (together 1,250,000) and `done` is low.
- R2: Word select 0 addresses the low word, which holds limit bits 15:1. A write stores `reg_wdata[15:1]`, and bit 0 always reads 0 whatever was written.
- R3: Word select 1 addresses the high word, which holds limit bits 20:16 in `reg_wdata[4:0]`. Bits 15:5 always read 0. A write to one word leaves the other word unchanged.
- R4: With terminal value L captured at a restart, `done` is high in exactly one cycle. That cycle is the one after the (L+1)-th rising edge that follows the edge sampling `restart`.
- R5: With a terminal value of zero, `done` pulses on the cycle right after the restart.
- R6: After `done` the timer is idle and gives no further `done` until `restart` is sampled again.
- R7: A `restart` sampled while an interval is running restarts the count from zero. `done` then follows the rule of R4, measured from the latest restart only.
- R8: When `restart` is sampled on the same edge that would end an interval, the restart wins. No `done` is produced for the old interval.
- R9: Limit writes made during an interval do not change that interval's length. They apply from the next restart.
- R10: All 21 bits take part in the count, so a terminal value with high-word bits set is honoured in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected limit word |
| reg_sel | input | 1 | Word select: 0 low word, 1 high word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word (combinational) |
| restart | input | 1 | Start or restart an interval |
| done | output | 1 | One-cycle pulse when the interval elapses |

## Verification
The bench measures the exact cycle of `done` for several terminal values. These include zero and a value that spans both words. A design off by one register would show up as `done` one cycle early or late. A design that ignored the high word would finish about 65,536 ticks early.

Other tests restart the timer mid-interval, and restart it on the very edge of terminal count. A design that did not reload the count would fire at the old time. A design that let terminal count win over restart would emit a stray pulse. A write made during an interval must not shorten that interval, which catches a design that compares against the live register. The readback tests catch an unmasked bit 0 or stray high bits.

// File: rtl/anlt_pkg.sv
// Package: shared sizes and helpers for the auto-negotiation link timer.
// Assumes the limit is split into equal-width register words, low word first.
package anlt_pkg;

    localparam int unsigned ANLT_LIMIT_W = 21;
    localparam int unsigned ANLT_WORD_W  = 16;
    localparam int unsigned ANLT_RESET_TICKS = 1_250_000;

    // Number of register words needed to hold a limit of the given width.
    function automatic int unsigned anlt_num_words(input int unsigned lim_w,
                                                   input int unsigned word_w);
        return (lim_w + word_w - 1) / word_w;
    endfunction

    // Width of a word-select field for the given word count (at least 1 bit).
    function automatic int unsigned anlt_sel_w(input int unsigned nwords);
        return (nwords > 1) ? $clog2(nwords) : 1;
    endfunction

endpackage

// File: rtl/anlt_limit_regs.sv
// Limit register bank: holds the terminal count across NUM_WORDS register
// words, low word first. Bit 0 of the limit is tied to zero, so the limit is
// always even. Read data is a combinational mux of the selected word.
// Assumes a synchronous active-low reset and one write per cycle.
module anlt_limit_regs #(
    parameter int unsigned LIMIT_W = anlt_pkg::ANLT_LIMIT_W,
    parameter int unsigned WORD_W  = anlt_pkg::ANLT_WORD_W,
    parameter int unsigned RESET_TICKS = anlt_pkg::ANLT_RESET_TICKS,
    localparam int unsigned NUM_WORDS = anlt_pkg::anlt_num_words(LIMIT_W, WORD_W),
    localparam int unsigned SEL_W = anlt_pkg::anlt_sel_w(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [LIMIT_W-1:0] limit
);

    localparam logic [LIMIT_W-1:0] RESET_VAL = LIMIT_W'(RESET_TICKS);

    logic [WORD_W-1:0] rd_words [NUM_WORDS];

    assign limit[0] = 1'b0;

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
        localparam int unsigned LO  = gi * WORD_W;
        localparam int unsigned TOP = ((LO + WORD_W) < LIMIT_W) ? (LO + WORD_W) : LIMIT_W;
        localparam int unsigned HI  = TOP - 1;
        localparam int unsigned WLO = (gi == 0) ? 1 : LO;
        localparam int unsigned SW  = HI - WLO + 1;

        logic [SW-1:0] word_q;

        // Store the writable bits of this word; reset loads the default limit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= RESET_VAL[HI:WLO];
            end else if (wr && (int'(sel) == gi)) begin
                word_q <= wdata[HI-LO:WLO-LO];
            end
        end

        assign limit[HI:WLO] = word_q;

        // Present the word zero-extended, with unused bits reading as zero.
        always_comb begin
            rd_words[gi] = '0;
            rd_words[gi][HI-LO:WLO-LO] = word_q;
        end

        // R2/R3: a write is reflected in the readback, masked to stored bits.
        a_r3_word_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && (int'(sel) == gi)) |=>
                (rd_words[gi][HI-LO:WLO-LO] == $past(wdata[HI-LO:WLO-LO])));
    end

    // Select the addressed word for readback.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (int'(sel) == i) rdata = rd_words[i];
        end
    end

    // R2: the low word never presents a set bit 0.
    a_r2_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (rdata[0] == 1'b0));

endmodule

// File: rtl/anlt_count_core.sv
// Counting core: on restart, captures the limit and counts up from zero one
// tick per clock. When the count equals the captured limit it raises done for
// one cycle and goes idle. Restart always has priority over terminal count.
// Assumes a synchronous active-low reset.
module anlt_count_core #(
    parameter int unsigned LIMIT_W = anlt_pkg::ANLT_LIMIT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [LIMIT_W-1:0] limit,
    output logic               done
);

    logic [LIMIT_W-1:0] count_q;
    logic [LIMIT_W-1:0] act_lim_q;
    logic               running_q;
    logic               done_q;
    logic               at_term;

    // Terminal count reached for the captured limit.
    assign at_term = running_q && (count_q == act_lim_q);

    // Counter, captured limit, run flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            act_lim_q <= '0;
            running_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (restart) begin
                count_q   <= '0;
                act_lim_q <= limit;
                running_q <= 1'b1;
            end else if (at_term) begin
                done_q    <= 1'b1;
                running_q <= 1'b0;
            end else if (running_q) begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    assign done = done_q;

    // R4: done lasts a single cycle.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R4: a running count never passes the captured limit.
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (count_q <= act_lim_q));

    // R6: the timer is idle whenever done is shown.
    a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !running_q);

    // R7: a restart reloads the count from zero and runs.
    a_r7_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (running_q && (count_q == '0)));

    // R8: a restart suppresses done on the following cycle.
    a_r8_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done_q);

    // R9: the captured limit holds while an interval runs.
    a_r9_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !restart) |=> $stable(act_lim_q));

endmodule

// File: rtl/anlt_link_timer.sv
// Top of the auto-negotiation link timer: a limit register bank on a simple
// word-addressed port feeding a counting core. Writes to the limit apply at
// the next restart. Assumes a single 125 MHz clock and synchronous
// active-low reset.
module anlt_link_timer #(
    parameter int unsigned LIMIT_W = anlt_pkg::ANLT_LIMIT_W,
    parameter int unsigned WORD_W  = anlt_pkg::ANLT_WORD_W,
    parameter int unsigned RESET_TICKS = anlt_pkg::ANLT_RESET_TICKS,
    localparam int unsigned NUM_WORDS = anlt_pkg::anlt_num_words(LIMIT_W, WORD_W),
    localparam int unsigned SEL_W = anlt_pkg::anlt_sel_w(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              restart,
    output logic              done
);

    logic [LIMIT_W-1:0] limit;

    anlt_limit_regs #(
        .LIMIT_W     (LIMIT_W),
        .WORD_W      (WORD_W),
        .RESET_TICKS (RESET_TICKS)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .limit (limit)
    );

    anlt_count_core #(
        .LIMIT_W (LIMIT_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .done    (done)
    );

    // R1: done is low in the cycle after a reset edge.
    a_r1_reset_done_low: assert property (@(posedge clk)
        !rst_n |=> !done);

endmodule

// File: tb/anlt_link_timer_tb.sv
// Directed bench for the link timer: one task per scenario, each checking
// its own results. Inputs change on the falling edge; outputs are sampled
// there too.
module anlt_link_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [0:0]  reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        restart = 1'b0;
    logic        done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    anlt_link_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .restart   (restart),
        .done      (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input bit sel, input logic [15:0] val);
        reg_sel = sel; reg_wdata = val; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_word(input bit sel, output logic [15:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic set_limit(input int lim);
        write_word(1'b0, lim[15:0]);
        write_word(1'b1, 16'(lim >> 16));
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    // Count falling edges until done is seen; n is -1 if not seen.
    task automatic wait_done(input int maxc, output int n);
        n = -1;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk);
            if (done) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        read_word(1'b0, v);
        check(v == 16'h12D0, "R1 low word reset", int'(v), 'h12D0);
        read_word(1'b1, v);
        check(v == 16'h0013, "R1 high word reset", int'(v), 'h0013);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        write_word(1'b0, 16'hABCD);
        read_word(1'b0, v);
        check(v == 16'hABCC, "R2 low word bit0 masked", int'(v), 'hABCC);
        read_word(1'b1, v);
        check(v == 16'h0013, "R3 high word untouched by low write", int'(v), 'h0013);
        write_word(1'b0, 16'h0001);
        read_word(1'b0, v);
        check(v == 16'h0000, "R2 write of bit0 ignored", int'(v), 0);
        write_word(1'b1, 16'hFFFF);
        read_word(1'b1, v);
        check(v == 16'h001F, "R3 high word upper bits zero", int'(v), 'h1F);
        read_word(1'b0, v);
        check(v == 16'h0000, "R3 low word untouched by high write", int'(v), 0);
    endtask

    task automatic t_interval(input int lim, input string req);
        int n;
        set_limit(lim);
        pulse_restart();
        wait_done(lim + 10, n);
        check(n == lim + 1, req, n, lim + 1);
        @(negedge clk);
        check(done == 1'b0, {req, " single-cycle"}, int'(done), 0);
    endtask

    task automatic t_idle();
        int hits = 0;
        set_limit(4);
        pulse_restart();
        repeat (5) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done) hits++;
        end
        check(hits == 0, "R6 no done while idle", hits, 0);
    endtask

    task automatic t_retrigger();
        int n;
        set_limit(10);
        pulse_restart();
        wait_done(3, n);
        check(n == -1, "R7 no early done", n, -1);
        pulse_restart();
        wait_done(30, n);
        check(n == 11, "R7 done from latest restart", n, 11);
    endtask

    task automatic t_collide();
        int n;
        set_limit(4);
        pulse_restart();
        repeat (4) @(negedge clk);
        pulse_restart();
        check(done == 1'b0, "R8 restart beats terminal", int'(done), 0);
        wait_done(20, n);
        check(n == 5, "R8 new interval length", n, 5);
    endtask

    task automatic t_write_mid();
        int n;
        set_limit(6);
        pulse_restart();
        write_word(1'b0, 16'd20);
        wait_done(30, n);
        check(n == 6, "R9 interval unchanged by write", n, 6);
        pulse_restart();
        wait_done(40, n);
        check(n == 21, "R9 new limit at next restart", n, 21);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_regs();
        t_interval(8, "R4 limit 8");
        t_interval(2, "R4 limit 2");
        t_interval(0, "R5 zero limit");
        t_idle();
        t_retrigger();
        t_collide();
        t_write_mid();
        t_interval(32'h10004, "R10 21-bit limit");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule